// File: doc/BRIEF.md
# Restricted SPI Flash Command Engine

This block is a host-side SPI master that carries out a single serial-flash transaction at a time. The host writes a command byte and up to four further bytes into five byte slots, one byte per write. It then chooses how many bytes go out and how many come back, picks one of two serial clock rates, and pulses a start strobe. From there the engine runs the whole bus sequence by itself. It drops the only chip select, shifts the chosen bytes out most significant bit first, and clocks in the requested reply bytes. It then releases chip select and raises a done flag.

The sequence is half duplex: it always writes first and reads second. The only lengths it accepts come from two small fixed sets. If a start asks for any other length, the engine raises an error flag and leaves the bus untouched. The engine serves one slave, and each start makes exactly one chip-select window.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: `out_len` is a plain binary byte count that includes the command byte. Only 1, 2, 4 and 5 are legal. A start with a legal count and an idle engine is accepted.
- R2: A start with `out_len` of 0, 3, 6 or 7 raises `err` on the next clock edge. `cs_n` stays high, `sck` stays low and `busy` stays low.
- R3: `in_len` is a binary count of 0 to 3 reply bytes. An accepted start produces exactly 8*(out_len+in_len) rising `sck` edges.
- R4: MOSI sends slot 0, the command byte, first, followed by slots 1, 2 and so on, each byte MSB first. Slots at or beyond `out_len` are never sent. MOSI is 0 during the reply bytes.
- R5: Each accepted start produces exactly one chip-select window. `cs_n` stays low for (2N+1)*H clock cycles, where N = 8*(out_len+in_len) is the bit count and H is the half-period from R7. This leaves one half-period before the first `sck` edge and one after the last.
- R6: The bus runs in mode 0. `sck` is low whenever `cs_n` is high. MOSI changes only while `sck` is low. MISO is sampled on the clock edge where `sck` rises.
- R7: The `half_rate` value seen at start selects the half-period H. With `half_rate` = 0, H is 1 clock cycle. With `half_rate` = 1, H is 2 clock cycles, which halves the serial clock rate.
- R8: `busy` rises on the clock edge that accepts a start and falls on the edge that raises `cs_n`. A start that arrives while `busy` is high is ignored, and the running transaction completes unchanged.
- R9: Reply bytes land in `rx_data` in arrival order. The first byte goes to bits [7:0], the second to [15:8] and the third to [23:16]. `rx_data` is cleared on an accepted start, so positions with no reply byte read as 0.
- R10: `done` rises together with the release of `cs_n`. An accepted start clears both `done` and `err`. After reset, `cs_n` is 1 and `sck`, `busy`, `done`, `err` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte slot write strobe |
| wr_sel | input | 3 | Slot index 0..4 (values above 4 are dropped) |
| wr_byte | input | 8 | Byte written into the selected slot |
| out_len | input | 3 | Outgoing byte count, command included |
| in_len | input | 2 | Reply byte count |
| half_rate | input | 1 | 1 selects the halved serial clock |
| start | input | 1 | One-cycle transaction start strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction completed |
| err | output | 1 | Last start request had an illegal length |
| rx_data | output | 24 | Reply bytes, first in bits [7:0] |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Every result of a transaction is fixed by the lengths and the rate chosen at start. Chip select falls one edge after the start strobe and stays low for (2N+1)*H cycles. `done` and the final `rx_data` appear on the edge where it rises, and an illegal start shows `err` one edge later. The bench waits until `busy` falls and then samples one negative clock edge later, so each result is read well after its own due edge. A slave model counts `sck` rising edges, records MOSI and chip-select falls, and counts the clock cycles spent with `cs_n` low. The bench compares these counts with the formulas above and does not read any internal timing of the design.

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_byte,
  input  logic [2:0]  out_len,
  input  logic [1:0]  in_len,
  input  logic        half_rate,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [23:0] rx_data,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} st_t;

  st_t         st_q;
  logic [7:0]  slot_q [5];
  logic [39:0] tx_q;
  logic [5:0]  bcnt_q, last_q, rd_from_q;
  logic        slow_q, div_q, sck_q;
  logic [23:0] rx_q;
  logic        done_q, err_q;

  logic        len_ok, take, tick;
  logic [5:0]  rd_idx;
  logic [5:0]  nbits;
  logic [39:0] tx_load;

  assign len_ok = (out_len == 3'd1) || (out_len == 3'd2) || (out_len == 3'd4) || (out_len == 3'd5);
  assign take   = start && (st_q == S_IDLE);
  assign tick   = !slow_q || div_q;
  assign rd_idx = bcnt_q - rd_from_q;
  assign nbits  = {({1'b0, out_len} + {2'b00, in_len}), 3'b000};

  always_comb begin
    for (int i = 0; i < 5; i++)
      tx_load[39-8*i -: 8] = (i < int'(out_len)) ? slot_q[i] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) slot_q[i] <= 8'h00;
    end else if (wr_en && wr_sel < 3'd5) begin
      slot_q[wr_sel] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      tx_q      <= '0;
      bcnt_q    <= '0;
      last_q    <= '0;
      rd_from_q <= '0;
      slow_q    <= 1'b0;
      div_q     <= 1'b0;
      sck_q     <= 1'b0;
      rx_q      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      div_q <= (st_q == S_IDLE) ? 1'b0 : ~div_q;
      case (st_q)
        S_IDLE: begin
          if (take && !len_ok) begin
            err_q <= 1'b1;
          end else if (take) begin
            err_q     <= 1'b0;
            done_q    <= 1'b0;
            rx_q      <= '0;
            tx_q      <= tx_load;
            bcnt_q    <= '0;
            last_q    <= nbits - 6'd1;
            rd_from_q <= {out_len, 3'b000};
            slow_q    <= half_rate;
            div_q     <= 1'b0;
            st_q      <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (tick) begin
            sck_q <= 1'b1;
            st_q  <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              if (bcnt_q == last_q) begin
                st_q <= S_TRAIL;
                tx_q <= '0;
              end else begin
                bcnt_q <= bcnt_q + 6'd1;
                tx_q   <= {tx_q[38:0], 1'b0};
              end
            end
          end
        end
        S_TRAIL: begin
          if (tick) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if ((st_q == S_LEAD && tick) || (st_q == S_SHIFT && tick && !sck_q)) begin
        if (bcnt_q >= rd_from_q)
          rx_q[{rd_idx[4:3], ~rd_idx[2:0]}] <= miso;
      end
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign cs_n    = (st_q == S_IDLE);
  assign sck     = sck_q;
  assign mosi    = tx_q[39];
  assign done    = done_q;
  assign err     = err_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/spi_flash_cmd_engine_chk.sv
module spi_flash_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  out_len,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi
);
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r6_mosi_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  a_r8_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r10_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r2_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (out_len == 3'd0 || out_len == 3'd3 || out_len > 3'd5)) |=> (err && cs_n && !busy));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !$fell(cs_n)) |=> !done || !busy);
endmodule

bind spi_flash_cmd_engine spi_flash_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_len(out_len), .busy(busy),
  .done(done), .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi)
);

// File: tb/spi_flash_cmd_engine_tb.sv
module spi_flash_cmd_engine_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, half_rate = 0, start = 0;
  logic [2:0] wr_sel = 0, out_len = 0;
  logic [1:0] in_len = 0;
  logic [7:0] wr_byte = 0;
  logic busy, done, err, cs_n, sck, mosi, miso;
  logic [23:0] rx_data;

  always #4 clk = ~clk;

  spi_flash_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .out_len(out_len), .in_len(in_len), .half_rate(half_rate), .start(start),
    .busy(busy), .done(done), .err(err), .rx_data(rx_data), .cs_n(cs_n),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_bad = 0, reported = 0;
  int rises = 0, cs_falls = 0, low_cyc = 0, base = 0, rd_off = 0;
  logic [23:0] slave_q = 0;
  logic mosi_log [4096];

  always @(posedge sck) begin
    if (rises < 4096) mosi_log[rises] = mosi;
    rises = rises + 1;
  end
  always @(negedge cs_n) cs_falls = cs_falls + 1;
  always @(posedge clk) if (!cs_n) low_cyc = low_cyc + 1;

  assign miso = (rises - base - rd_off >= 0 && rises - base - rd_off < 24)
                ? slave_q[23 - (rises - base - rd_off)] : 1'b1;

  // {out_len, in_len, half_rate, five slot bytes, three slave bytes}
  localparam int NV = 6;
  localparam logic [69:0] VEC [NV] = '{
    {3'd1, 2'd0, 1'b0, 40'h9F_00_00_00_00, 24'h00_00_00},
    {3'd1, 2'd3, 1'b0, 40'h9F_77_66_55_44, 24'hA5_3C_E1},
    {3'd2, 2'd1, 1'b1, 40'h05_00_FF_FF_FF, 24'h81_00_00},
    {3'd4, 2'd2, 1'b0, 40'h03_12_34_56_99, 24'hDE_AD_00},
    {3'd5, 2'd3, 1'b1, 40'h0B_AB_CD_EF_FF, 24'h12_34_56},
    {3'd5, 2'd0, 1'b0, 40'h02_11_22_33_44, 24'hFF_FF_FF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (reported == 0) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic load(input logic [39:0] b);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr_en = 1; wr_sel = 3'(i); wr_byte = b[39-8*i -: 8];
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input logic [2:0] ol, input logic [1:0] il, input logic hr);
    @(negedge clk);
    out_len = ol; in_len = il; half_rate = hr; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((busy || !done) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) check(0, "R10", "timeout waiting for done", t, 0);
    @(negedge clk);
  endtask

  task automatic run(input logic [69:0] v);
    logic [2:0] ol; logic [1:0] il; logic hr; logic [39:0] tb; logic [23:0] sl;
    int nb, h, r0, c0, l0, bad;
    logic [23:0] exp_rx;
    {ol, il, hr, tb, sl} = v;
    load(tb);
    nb = 8 * (int'(ol) + int'(il));
    h = hr ? 2 : 1;
    base = rises; rd_off = 8 * int'(ol); slave_q = sl;
    r0 = rises; c0 = cs_falls; l0 = low_cyc;
    pulse(ol, il, hr);
    wait_idle();
    check(rises - r0 == nb, "R3", "sck rising edges", rises - r0, nb);
    check(cs_falls - c0 == 1, "R5", "chip select windows", cs_falls - c0, 1);
    check(low_cyc - l0 == (2 * nb + 1) * h, "R7", "cs low cycles", low_cyc - l0, (2 * nb + 1) * h);
    bad = 0;
    for (int i = 0; i < nb; i++) begin
      if (i < 8 * int'(ol)) begin
        if (mosi_log[r0 + i] !== tb[39 - i]) bad++;
      end else if (mosi_log[r0 + i] !== 1'b0) bad++;
    end
    check(bad == 0, "R4", "mosi bit errors", bad, 0);
    exp_rx = 24'h0;
    if (il >= 2'd1) exp_rx[7:0]   = sl[23:16];
    if (il >= 2'd2) exp_rx[15:8]  = sl[15:8];
    if (il >= 2'd3) exp_rx[23:16] = sl[7:0];
    check(rx_data === exp_rx, "R9", "rx_data", rx_data, exp_rx);
    check(done && !busy && !err && cs_n && !sck, "R10", "end flags {done,busy,err}",
          {done, busy, err}, 3'b100);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int c0, r0;
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !busy && !done && !err && rx_data == 0, "R10", "reset state",
          {cs_n, sck, busy, done, err}, 5'b10000);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run(VEC[k]);

    // R2: every illegal outgoing count
    for (int bad_len = 0; bad_len < 8; bad_len++) begin
      if (bad_len == 0 || bad_len == 3 || bad_len == 6 || bad_len == 7) begin
        c0 = cs_falls; r0 = rises;
        pulse(3'(bad_len), 2'd1, 1'b0);
        check(err && !busy && cs_n, "R2", "illegal start flags {err,busy}", {err, busy}, 2'b10);
        repeat (4) @(negedge clk);
        check(cs_falls == c0 && rises == r0, "R2", "bus activity on illegal start",
              cs_falls - c0 + rises - r0, 0);
      end
    end

    // R1 / R10: a legal start clears err and runs
    run({3'd2, 2'd2, 1'b0, 40'hAA_55_00_00_00, 24'h0F_F0_00});
    check(err == 0, "R1", "err after legal start", err, 0);

    // R8: start while busy is ignored
    load(40'hC3_00_00_00_00);
    base = rises; rd_off = 8; slave_q = 24'h6E_00_00;
    c0 = cs_falls; r0 = rises;
    pulse(3'd1, 2'd1, 1'b1);
    check(busy, "R8", "busy after accepted start", busy, 1);
    repeat (3) @(negedge clk);
    start = 1; out_len = 3'd5; in_len = 2'd3; half_rate = 1'b0;
    @(negedge clk);
    start = 0;
    wait_idle();
    check(cs_falls - c0 == 1, "R8", "windows with start while busy", cs_falls - c0, 1);
    check(rises - r0 == 16, "R8", "edges with start while busy", rises - r0, 16);
    check(rx_data === 24'h00_00_6E, "R8", "rx_data with start while busy", rx_data, 24'h6E);

    // R9: rx cleared at the next accepted start with no reply bytes
    run({3'd1, 2'd0, 1'b1, 40'h06_00_00_00_00, 24'h00_00_00});
    check(rx_data === 24'h0, "R9", "rx cleared", rx_data, 0);
    summary();
  end
endmodule